// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a processor's fetch unit and runs hardware loops without any branch cost. It holds three pieces of loop state: the address of the loop's last instruction word, an iteration counter, and a flag that marks a loop as running. Each cycle it compares the fetch program counter with the stored last-word address. On a match it either sends fetch back to the loop's first word in the same cycle, or it lets fetch fall through and ends the loop.

Loops can nest because each start saves the enclosing loop's context on an external return stack. The start saves two entries. The first holds the old last-word address and counter. The second holds the new loop's first-word address and a status word that carries the old loop flag. A normal exit pulls both entries back. An early-termination command pulls them back in the same way. Stack moves use a request/acknowledge handshake. While one is outstanding the block reports busy and ignores new start and termination commands. Decode and the stack storage are outside the block.

Top module: `hwl_loop_ctrl`

## Requirements
- R1: After reset, loop_active, busy, stk_push, stk_pop and redirect are all 0, and la_q and lc_q are 0.
- R2: An accepted start pushes two entries in this order. First comes {la_q, lc_q} with the address in bits 31:16 and the counter in bits 15:0. Second comes {start address, status word}. The status word is status_in with bit 15 replaced by the loop flag as it was before the start.
- R3: Once the second push is acknowledged, la_q holds the end address, lc_q holds the count, loop_active is 1 and busy returns to 0.
- R4: While the loop is active and the block is idle, a valid fetch at pc equal to la_q with lc_q not 1 raises redirect. In that cycle next_pc is bits 31:16 of the stack top, and lc_q drops by one on the following cycle. Any other fetch gives next_pc = fetch_pc + 1 with redirect low.
- R5: A valid fetch at la_q with lc_q equal to 1 gives no redirect and next_pc = la_q + 1. The block then pops two entries. The first pop restores loop_active from bit 15 of that entry. The second pop restores la_q from bits 31:16 and lc_q from bits 15:0.
- R6: term_req while the loop is active and the block is idle starts the same two-pop restore. It gives no redirect.
- R7: busy is high while any stack request is outstanding. A request stays asserted, with its data unchanged, until stk_ack. do_start and term_req are ignored while busy.
- R8: lc_wr while idle loads lc_q on the next cycle, and the loaded value governs the next end-of-loop check. If the write falls in a redirect cycle, the written value replaces the decrement.
- R9: stk_push and stk_pop are never high together.
- R10: With loop_active low, no fetch redirects, and term_req causes no stack move and no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| do_start | input | 1 | Start a loop (one-cycle command) |
| do_count | input | 16 | Iteration count for the new loop |
| do_end_addr | input | 16 | Address of the loop's last instruction word |
| do_start_addr | input | 16 | Address of the loop's first instruction word |
| status_in | input | 16 | Processor status word saved with the loop |
| term_req | input | 1 | Early termination of the current loop |
| fetch_valid | input | 1 | fetch_pc carries a fetch this cycle |
| fetch_pc | input | 16 | Current fetch address |
| lc_wr | input | 1 | Software write to the loop counter |
| lc_wdata | input | 16 | Value for the software write |
| next_pc | output | 16 | Next fetch address |
| redirect | output | 1 | next_pc is a branch back to the loop start |
| loop_active | output | 1 | Loop flag |
| la_q | output | 16 | Last-word address register |
| lc_q | output | 16 | Loop counter register |
| busy | output | 1 | A stack transaction is in progress |
| stk_push | output | 1 | Push request |
| stk_pop | output | 1 | Pop request |
| stk_wdata | output | 32 | Entry to push |
| stk_top | input | 32 | Current top entry of the stack |
| stk_ack | input | 1 | The stack accepts the request this cycle |

## Verification
redirect and next_pc are combinational, so the bench samples them one nanosecond after it drives a fetch, in the same cycle. A counter decrement or software write shows in lc_q one cycle later, and the bench compares it at the next idle sample. Restores and loop loads complete on the edge that carries the final acknowledge. The stack model in the bench delays acknowledges at random, so the bench does not count cycles for these. It waits until busy is low and then compares la_q, lc_q, loop_active and the stack depth with its shadow model.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_CTX,
      ST_PUSH_RET,
      ST_POP_RET,
      ST_POP_CTX
   } hwl_state_e;
endpackage

// File: rtl/hwl_seq.sv
module hwl_seq
   import hwl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_req,
   input  logic       stop_req,
   input  logic       stk_ack,
   output hwl_state_e state,
   output logic       busy,
   output logic       push,
   output logic       pop,
   output logic       load_en,
   output logic       flag_rst_en,
   output logic       ctx_en
);
   hwl_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:     if (start_req) nxt = ST_PUSH_CTX;
                      else if (stop_req) nxt = ST_POP_RET;
         ST_PUSH_CTX: if (stk_ack) nxt = ST_PUSH_RET;
         ST_PUSH_RET: if (stk_ack) nxt = ST_IDLE;
         ST_POP_RET:  if (stk_ack) nxt = ST_POP_CTX;
         ST_POP_CTX:  if (stk_ack) nxt = ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign busy        = (state != ST_IDLE);
   assign push        = (state == ST_PUSH_CTX) || (state == ST_PUSH_RET);
   assign pop         = (state == ST_POP_RET) || (state == ST_POP_CTX);
   assign load_en     = (state == ST_PUSH_RET) && stk_ack;
   assign flag_rst_en = (state == ST_POP_RET) && stk_ack;
   assign ctx_en      = (state == ST_POP_CTX) && stk_ack;
endmodule

// File: rtl/hwl_end_detect.sv
module hwl_end_detect #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          en,
   input  logic [AW-1:0] fetch_pc,
   input  logic [AW-1:0] la,
   input  logic [CW-1:0] lc,
   output logic          wrap,
   output logic          last
);
   logic hit;
   logic one;

   assign hit  = en && (fetch_pc == la);
   assign one  = (lc == CW'(1));
   assign wrap = hit && !one;
   assign last = hit && one;
endmodule

// File: rtl/hwl_regs.sv
module hwl_regs #(
   parameter int AW         = 16,
   parameter int CW         = 16,
   parameter bit WRITE_WINS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic [AW-1:0] load_la,
   input  logic [CW-1:0] load_lc,
   input  logic          dec_en,
   input  logic          sw_wr,
   input  logic [CW-1:0] sw_data,
   input  logic          flag_rst_en,
   input  logic          flag_val,
   input  logic          ctx_en,
   input  logic [AW-1:0] ctx_la,
   input  logic [CW-1:0] ctx_lc,
   output logic [AW-1:0] la_q,
   output logic [CW-1:0] lc_q,
   output logic          flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       la_q <= '0;
      else if (ctx_en)  la_q <= ctx_la;
      else if (load_en) la_q <= load_la;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q <= 1'b0;
      else if (flag_rst_en) flag_q <= flag_val;
      else if (load_en)     flag_q <= 1'b1;
   end

   generate
      if (WRITE_WINS) begin : g_wr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lc_q <= '0;
            else if (ctx_en)  lc_q <= ctx_lc;
            else if (load_en) lc_q <= load_lc;
            else if (sw_wr)   lc_q <= sw_data;
            else if (dec_en)  lc_q <= lc_q - 1'b1;
         end
      end else begin : g_dec_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lc_q <= '0;
            else if (ctx_en)  lc_q <= ctx_lc;
            else if (load_en) lc_q <= load_lc;
            else if (dec_en)  lc_q <= lc_q - 1'b1;
            else if (sw_wr)   lc_q <= sw_data;
         end
      end
   endgenerate
endmodule

// File: rtl/hwl_loop_ctrl.sv
module hwl_loop_ctrl
   import hwl_pkg::*;
#(
   parameter int AW         = 16,
   parameter int CW         = 16,
   parameter int SW         = 16,
   parameter bit WRITE_WINS = 1'b1,
   localparam int EW        = AW + CW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          do_start,
   input  logic [CW-1:0] do_count,
   input  logic [AW-1:0] do_end_addr,
   input  logic [AW-1:0] do_start_addr,
   input  logic [SW-1:0] status_in,
   input  logic          term_req,
   input  logic          fetch_valid,
   input  logic [AW-1:0] fetch_pc,
   input  logic          lc_wr,
   input  logic [CW-1:0] lc_wdata,
   output logic [AW-1:0] next_pc,
   output logic          redirect,
   output logic          loop_active,
   output logic [AW-1:0] la_q,
   output logic [CW-1:0] lc_q,
   output logic          busy,
   output logic          stk_push,
   output logic          stk_pop,
   output logic [EW-1:0] stk_wdata,
   input  logic [EW-1:0] stk_top,
   input  logic          stk_ack
);
   localparam int LF_BIT = SW - 1;

   generate
      if (CW != SW) begin : g_bad_width
         $error("hwl_loop_ctrl: counter and status widths must match");
      end
      if (AW < 2 || SW < 2) begin : g_bad_small
         $error("hwl_loop_ctrl: address and status need at least 2 bits");
      end
   endgenerate

   hwl_state_e    state;
   logic          load_en, flag_rst_en, ctx_en;
   logic          start_req, stop_req, det_en, wrap, last;
   logic [AW-1:0] pend_start, pend_end;
   logic [CW-1:0] pend_count;
   logic [SW-1:0] pend_status;

   assign start_req = do_start && !busy;
   assign det_en    = !busy && loop_active && fetch_valid && !do_start && !term_req;
   assign stop_req  = !busy && !do_start && loop_active && (term_req || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_start  <= '0;
         pend_end    <= '0;
         pend_count  <= '0;
         pend_status <= '0;
      end else if (start_req) begin
         pend_start  <= do_start_addr;
         pend_end    <= do_end_addr;
         pend_count  <= do_count;
         pend_status <= {loop_active, status_in[SW-2:0]};
      end
   end

   hwl_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_req   (start_req),
      .stop_req    (stop_req),
      .stk_ack     (stk_ack),
      .state       (state),
      .busy        (busy),
      .push        (stk_push),
      .pop         (stk_pop),
      .load_en     (load_en),
      .flag_rst_en (flag_rst_en),
      .ctx_en      (ctx_en)
   );

   hwl_end_detect #(.AW(AW), .CW(CW)) u_det (
      .en       (det_en),
      .fetch_pc (fetch_pc),
      .la       (la_q),
      .lc       (lc_q),
      .wrap     (wrap),
      .last     (last)
   );

   hwl_regs #(.AW(AW), .CW(CW), .WRITE_WINS(WRITE_WINS)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_en     (load_en),
      .load_la     (pend_end),
      .load_lc     (pend_count),
      .dec_en      (wrap),
      .sw_wr       (lc_wr && !busy),
      .sw_data     (lc_wdata),
      .flag_rst_en (flag_rst_en),
      .flag_val    (stk_top[LF_BIT]),
      .ctx_en      (ctx_en),
      .ctx_la      (stk_top[EW-1 -: AW]),
      .ctx_lc      (stk_top[CW-1:0]),
      .la_q        (la_q),
      .lc_q        (lc_q),
      .flag_q      (loop_active)
   );

   assign redirect  = wrap;
   assign next_pc   = wrap ? stk_top[EW-1 -: AW] : fetch_pc + 1'b1;
   assign stk_wdata = (state == ST_PUSH_CTX) ? {la_q, lc_q} : {pend_start, pend_status};
endmodule

// File: rtl/hwl_loop_ctrl_chk.sv
module hwl_loop_ctrl_chk #(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int EW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fetch_valid,
   input logic [AW-1:0] fetch_pc,
   input logic          lc_wr,
   input logic          redirect,
   input logic          loop_active,
   input logic [AW-1:0] la_q,
   input logic [CW-1:0] lc_q,
   input logic          busy,
   input logic          stk_push,
   input logic          stk_pop,
   input logic [EW-1:0] stk_wdata,
   input logic          stk_ack
);
   p_push_pop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(stk_push && stk_pop));

   p_push_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stk_push && !stk_ack |=> stk_push && $stable(stk_wdata));

   p_pop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stk_pop && !stk_ack |=> stk_pop);

   p_ops_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_push || stk_pop) |-> busy);

   p_redir_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> loop_active && fetch_valid && !busy && (fetch_pc == la_q));

   p_redir_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      redirect && !lc_wr |=> lc_q == CW'($past(lc_q) - 1'b1));

   p_no_redir_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_active |-> !redirect);

   p_load_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && $past(stk_push) |-> loop_active);
endmodule

bind hwl_loop_ctrl hwl_loop_ctrl_chk #(.AW(AW), .CW(CW), .EW(EW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_valid (fetch_valid),
   .fetch_pc    (fetch_pc),
   .lc_wr       (lc_wr),
   .redirect    (redirect),
   .loop_active (loop_active),
   .la_q        (la_q),
   .lc_q        (lc_q),
   .busy        (busy),
   .stk_push    (stk_push),
   .stk_pop     (stk_pop),
   .stk_wdata   (stk_wdata),
   .stk_ack     (stk_ack)
);

// File: tb/sim_hwl_loop_ctrl.sv
`timescale 1ns/1ps
module sim_hwl_loop_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        do_start = 1'b0;
   logic [15:0] do_count = '0, do_end_addr = '0, do_start_addr = '0, status_in = '0;
   logic        term_req = 1'b0, fetch_valid = 1'b0, lc_wr = 1'b0;
   logic [15:0] fetch_pc = '0, lc_wdata = '0;
   logic [15:0] next_pc, la_q, lc_q;
   logic        redirect, loop_active, busy, stk_push, stk_pop;
   logic [31:0] stk_wdata, stk_top;
   logic        stk_ack = 1'b0;

   always #2.5 clk = ~clk;

   hwl_loop_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .do_start(do_start), .do_count(do_count),
      .do_end_addr(do_end_addr), .do_start_addr(do_start_addr), .status_in(status_in),
      .term_req(term_req), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .lc_wr(lc_wr), .lc_wdata(lc_wdata), .next_pc(next_pc), .redirect(redirect),
      .loop_active(loop_active), .la_q(la_q), .lc_q(lc_q), .busy(busy),
      .stk_push(stk_push), .stk_pop(stk_pop), .stk_wdata(stk_wdata),
      .stk_top(stk_top), .stk_ack(stk_ack)
   );

   // external stack model with random acknowledge delay
   logic [31:0] bmem [0:15];
   int          bsp = 0;
   assign stk_top = (bsp == 0) ? 32'h0 : bmem[bsp-1];

   always @(negedge clk) stk_ack = (stk_push || stk_pop) && ($urandom % 3 != 0);

   always @(posedge clk) begin
      if (stk_ack && stk_push) begin
         bmem[bsp] <= stk_wdata;
         bsp <= bsp + 1;
      end else if (stk_ack && stk_pop) begin
         bsp <= bsp - 1;
      end
   end

   int errors = 0, checks = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // shadow model
   logic [15:0] sh_la = '0, sh_lc = '0;
   logic        sh_flag = 1'b0;
   logic [31:0] shstk [0:15];
   int          shsp = 0;
   bit          pending = 1'b0;
   logic [15:0] pc = '0;
   int          wr_cyc = -1;
   logic [15:0] wr_val = '0;

   task automatic apply_restore();
      logic [31:0] e2, e1;
      e2 = shstk[shsp-1];
      e1 = shstk[shsp-2];
      shsp -= 2;
      sh_flag = e2[15];
      sh_la = e1[31:16];
      sh_lc = e1[15:0];
      pending = 1'b0;
      chk(loop_active == sh_flag, "R5 flag restore", {31'b0, loop_active}, {31'b0, sh_flag});
      chk(la_q == sh_la, "R5 la restore", {16'b0, la_q}, {16'b0, sh_la});
      chk(lc_q == sh_lc, "R5 lc restore", {16'b0, lc_q}, {16'b0, sh_lc});
      chk(bsp == shsp, "R5 stack depth", bsp, shsp);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy);
      #1;
      if (pending) apply_restore();
   endtask

   task automatic start_loop(input logic [15:0] s, input logic [15:0] e, input logic [15:0] c, input bit bogus);
      logic [15:0] st;
      int          sp0;
      st = 16'($urandom);
      @(negedge clk);
      sp0 = bsp;
      fetch_valid = 1'b0;
      do_start = 1'b1; do_start_addr = s; do_end_addr = e; do_count = c; status_in = st;
      @(negedge clk);
      if (bogus) begin
         // second command while busy: must be ignored (R7)
         do_start_addr = 16'hDEAD; do_end_addr = 16'hBEEF; do_count = 16'd9; term_req = 1'b1;
         chk(busy == 1'b1, "R7 busy during push", {31'b0, busy}, 32'd1);
         @(negedge clk);
         term_req = 1'b0;
      end
      do_start = 1'b0;
      do_start_addr = '0; do_end_addr = '0; do_count = '0;
      wait_idle();
      shstk[shsp] = {sh_la, sh_lc};
      shstk[shsp+1] = {s, sh_flag, st[14:0]};
      shsp += 2;
      chk(bsp == sp0 + 2, "R7 exactly two pushes", bsp, sp0 + 2);
      chk(bmem[bsp-2] == shstk[shsp-2], "R2 first entry", bmem[bsp-2], shstk[shsp-2]);
      chk(bmem[bsp-1] == shstk[shsp-1], "R2 second entry", bmem[bsp-1], shstk[shsp-1]);
      sh_la = e; sh_lc = c; sh_flag = 1'b1;
      chk(la_q == e, "R3 la load", {16'b0, la_q}, {16'b0, e});
      chk(lc_q == c, "R3 lc load", {16'b0, lc_q}, {16'b0, c});
      chk(loop_active == 1'b1, "R3 flag set", {31'b0, loop_active}, 32'd1);
   endtask

   task automatic run_fetch(input int n);
      for (int cyc = 0; cyc < n; cyc++) begin
         bit          hit, exp_red;
         logic [15:0] exp_next;
         @(negedge clk);
         if (busy) begin
            fetch_valid = 1'b0; lc_wr = 1'b0;
         end else begin
            fetch_valid = 1'b1; fetch_pc = pc;
            lc_wr = (cyc == wr_cyc); lc_wdata = wr_val;
            #1;
            if (pending) apply_restore();
            chk(lc_q == sh_lc, "R4 lc tracks", {16'b0, lc_q}, {16'b0, sh_lc});
            hit = sh_flag && (pc == sh_la);
            exp_red = hit && (sh_lc != 16'd1);
            exp_next = exp_red ? shstk[shsp-1][31:16] : pc + 16'd1;
            chk(redirect == exp_red, hit ? "R4 end check redirect" : "R10 no redirect", {31'b0, redirect}, {31'b0, exp_red});
            chk(next_pc == exp_next, hit ? "R5 next pc at end" : "R4 next pc", {16'b0, next_pc}, {16'b0, exp_next});
            if (lc_wr) sh_lc = wr_val;          // R8 write replaces decrement
            else if (exp_red) sh_lc = sh_lc - 16'd1;
            if (hit && !exp_red) pending = 1'b1;
            pc = exp_next;
         end
      end
      @(negedge clk);
      fetch_valid = 1'b0; lc_wr = 1'b0; wr_cyc = -1;
      wait_idle();
   endtask

   task automatic terminate();
      int sp0;
      @(negedge clk);
      sp0 = bsp;
      fetch_valid = 1'b0; term_req = 1'b1;
      @(negedge clk);
      term_req = 1'b0;
      #1;
      if (sh_flag) begin
         pending = 1'b1;
         chk(busy == 1'b1, "R6 term starts restore", {31'b0, busy}, 32'd1);
         chk(redirect == 1'b0, "R6 no redirect", {31'b0, redirect}, 32'd0);
         wait_idle();
      end else begin
         chk(busy == 1'b0, "R10 term ignored busy", {31'b0, busy}, 32'd0);
         @(negedge clk);
         chk(bsp == sp0, "R10 term no stack op", bsp, sp0);
      end
   endtask

   initial begin
      void'($urandom(32'd1357));
      #12;
      #1;
      chk(loop_active == 0 && busy == 0, "R1 reset flag/busy", {30'b0, loop_active, busy}, 32'd0);
      chk(stk_push == 0 && stk_pop == 0 && redirect == 0, "R1 reset ops", {29'b0, stk_push, stk_pop, redirect}, 32'd0);
      chk(la_q == 0 && lc_q == 0, "R1 reset regs", {la_q, lc_q}, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // R10: no loop running
      terminate();
      pc = 16'h0000;
      run_fetch(3);

      // simple loop plus a command issued while busy (R7)
      start_loop(16'h0040, 16'h0042, 16'd3, 1'b1);
      pc = 16'h0040;
      run_fetch(14);
      chk(loop_active == 1'b0, "R5 loop finished", {31'b0, loop_active}, 32'd0);

      // count of one: single pass, immediate exit (R5)
      start_loop(16'h0080, 16'h0080, 16'd1, 1'b0);
      pc = 16'h0080;
      run_fetch(4);

      // nested loops
      start_loop(16'h0100, 16'h010F, 16'd2, 1'b0);
      start_loop(16'h0104, 16'h0106, 16'd2, 1'b0);
      pc = 16'h0104;
      run_fetch(60);
      chk(loop_active == 1'b0 && bsp == 0, "R5 nested unwound", bsp, 0);

      // R8: software write in the redirect cycle
      start_loop(16'h0200, 16'h0201, 16'd2, 1'b0);
      pc = 16'h0200;
      wr_cyc = 1; wr_val = 16'd4;
      run_fetch(16);

      // R8: software write in a plain cycle
      start_loop(16'h0220, 16'h0222, 16'd5, 1'b0);
      pc = 16'h0220;
      wr_cyc = 1; wr_val = 16'd1;
      run_fetch(10);

      // R6: early termination inside a nested loop
      start_loop(16'h0300, 16'h0310, 16'd3, 1'b0);
      start_loop(16'h0302, 16'h0303, 16'd6, 1'b0);
      pc = 16'h0302;
      run_fetch(5);
      terminate();
      chk(loop_active == 1'b1 && la_q == 16'h0310, "R6 outer context back", {15'b0, loop_active, la_q}, {15'b0, 1'b1, 16'h0310});
      terminate();

      // random loops
      for (int k = 0; k < 12; k++) begin
         logic [15:0] s, len, cnt;
         s = 16'h1000 + 16'($urandom % 256) * 16'd16;
         len = 16'($urandom % 4);
         cnt = 16'd1 + 16'($urandom % 4);
         start_loop(s, s + len, cnt, ($urandom % 2) == 1);
         pc = s;
         run_fetch(int'((len + 1) * cnt) + 8);
         chk(loop_active == 1'b0, "R5 random loop ended", {31'b0, loop_active}, 32'd0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule